// File: doc/BRIEF.md
# Pixel Degamma Curve Stage

This block linearises pixel data before a colour-space-conversion matrix. It holds one transfer curve, made of evenly spaced points, and applies that curve to the red, green and blue components alike. Each 16-bit component is mapped by linear interpolation between the two curve points on either side of it. Results above unity are saturated to the largest output code. Pixels enter and leave on a valid/ready stream and pass through a two-stage pipeline.

Software loads the curve through a two-register port. One register holds the point index and an auto-increment control. The other register is the data window into the curve. Setting auto-increment does not load the index. A full load therefore writes the index register twice: first to set position 0 with auto-increment clear, then to turn auto-increment on. All points then follow as consecutive data writes.

The stage is switched on in one of two ways, chosen by a parameter. With `TIE_TO_MATRIX` set, the matrix enable also switches the curve on. With it clear, the stage follows its own enable input. When the stage is off, pixels pass through unchanged, with the same latency as when it is on.

Top module: `degamma_lut`

## Requirements
- R1: After reset the index is 0, auto-increment is off, `out_valid` is 0, and the curve is the identity: point i (i = 0..32) holds i*2048, and points 33 and 34 hold 65536.
- R2: A write to the index register (`reg_addr`=0) with bit 16 clear turns auto-increment off and loads bits 15:0 as the index. A value of 35 or more loads index 0.
- R3: A write to the index register with bit 16 set turns auto-increment on and leaves the index unchanged.
- R4: A data write (`reg_addr`=1) stores bits 16:0 in the point at the current index. With auto-increment on, the index then advances by one, and after 34 it wraps to 0. With auto-increment off, the index stays put.
- R5: A read (`reg_rd`) puts its result on `reg_rdata` after the next clock edge. A data read returns the point at the current index and moves the index exactly as a data write does. An index read returns the auto-increment flag in bit 16 and the index in the low bits, and does not move the index.
- R6: With the stage on, a component x gives (P[s]*(2048-w) + P[s+1]*w + 1024) >> 11. Here s = x[15:11], w = x[10:0], and P is the curve.
- R7: An interpolated value above 65535 is output as 65535.
- R8: Red, green and blue all pass through the same single curve.
- R9: With `TIE_TO_MATRIX`=1, `csc_en` alone switches the stage on and `dg_en` has no effect. With it 0, `dg_en` alone switches the stage on.
- R10: With the stage off, each output component equals its input component. The enable is sampled when the pixel is accepted.
- R11: An accepted pixel appears on the output two clock edges later if the stream does not stall. `in_ready` = !`out_valid` || `out_ready`. While `out_valid` is high and `out_ready` is low, the output holds valid and keeps its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| csc_en | input | 1 | Matrix enable (also enables the stage when tied) |
| dg_en | input | 1 | Stage enable used when not tied |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | 0 = index register, 1 = data register |
| reg_wdata | input | 17 | Write data |
| reg_rdata | output | 17 | Read data, valid after the edge that follows a read |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_r | input | 16 | Red input |
| in_g | input | 16 | Green input |
| in_b | input | 16 | Blue input |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream ready |
| out_r | output | 16 | Red output |
| out_g | output | 16 | Green output |
| out_b | output | 16 | Blue output |

## Verification
The index checks assume that a cycle never carries a read strobe and a write strobe together. With both strobes in one cycle the step count is not defined. The bench issues register accesses one at a time, and it keeps them apart from pixel traffic whenever the curve is being reloaded. The stall check relies on the downstream stage holding `out_ready` low only while it really refuses data. The random ready pattern produces such stalls freely. The random pixel values are mixed with segment edges, zero and full scale, so every interpolation segment and the saturation path are reached.

// File: rtl/degamma_lut.sv
module degamma_lut #(
  parameter int CW            = 16,
  parameter int EW            = 17,
  parameter int NPTS          = 35,
  parameter int SEGB          = 5,
  parameter bit TIE_TO_MATRIX = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          csc_en,
  input  logic          dg_en,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic          reg_addr,
  input  logic [EW-1:0] reg_wdata,
  output logic [EW-1:0] reg_rdata,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [CW-1:0] in_r,
  input  logic [CW-1:0] in_g,
  input  logic [CW-1:0] in_b,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [CW-1:0] out_r,
  output logic [CW-1:0] out_g,
  output logic [CW-1:0] out_b
);
  localparam int IW   = $clog2(NPTS);
  localparam int FW   = CW - SEGB;
  localparam int TOP  = 1 << SEGB;
  localparam int ONE  = 1 << CW;
  localparam int STEP = ONE / TOP;
  localparam int PW   = EW + FW + 2;
  localparam int AB   = EW - 1;

  function automatic logic [EW-1:0] init_val(int i);
    return (i <= TOP) ? EW'(i * STEP) : EW'(ONE);
  endfunction

  logic [EW-1:0] tbl [NPTS];
  logic [IW-1:0] idx;
  logic          auto_inc;

  wire          idx_wr  = reg_wr & ~reg_addr;
  wire          dat_acc = (reg_wr | reg_rd) & reg_addr;
  wire [IW-1:0] idx_nxt = (idx == IW'(NPTS - 1)) ? '0 : idx + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      idx      <= '0;
      auto_inc <= 1'b0;
    end else if (idx_wr) begin
      if (reg_wdata[AB]) auto_inc <= 1'b1;
      else begin
        auto_inc <= 1'b0;
        idx      <= (reg_wdata[AB-1:0] < AB'(NPTS)) ? IW'(reg_wdata[AB-1:0]) : '0;
      end
    end else if (dat_acc && auto_inc) begin
      idx <= idx_nxt;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NPTS; i++) tbl[i] <= init_val(i);
    end else if (reg_wr && reg_addr) begin
      tbl[idx] <= reg_wdata;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) reg_rdata <= '0;
    else if (reg_rd)
      reg_rdata <= reg_addr ? tbl[idx] : {auto_inc, {(EW-1-IW){1'b0}}, idx};

  wire active = TIE_TO_MATRIX ? csc_en : dg_en;
  wire adv    = ~out_valid | out_ready;
  assign in_ready = adv;

  logic [CW-1:0] pin  [3];
  logic [CW-1:0] raw1 [3];
  logic [EW-1:0] lo1  [3];
  logic [EW-1:0] hi1  [3];
  logic [CW-1:0] mix  [3];
  logic [CW-1:0] res  [3];
  logic          v1, en1, v2;

  assign pin[0] = in_r;
  assign pin[1] = in_g;
  assign pin[2] = in_b;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      v1  <= 1'b0;
      v2  <= 1'b0;
      en1 <= 1'b0;
    end else if (adv) begin
      v1  <= in_valid;
      v2  <= v1;
      en1 <= active;
    end

  always_ff @(posedge clk)
    if (adv)
      for (int c = 0; c < 3; c++) begin
        raw1[c] <= pin[c];
        lo1[c]  <= tbl[IW'(pin[c][CW-1:FW])];
        hi1[c]  <= tbl[IW'(pin[c][CW-1:FW]) + 1'b1];
        res[c]  <= en1 ? mix[c] : raw1[c];
      end

  for (genvar c = 0; c < 3; c++) begin : g_ch
    logic [PW-1:0] acc;
    wire  [FW-1:0] w = raw1[c][FW-1:0];
    assign acc = PW'(lo1[c]) * (PW'(1 << FW) - PW'(w))
               + PW'(hi1[c]) * PW'(w) + PW'(1 << (FW - 1));
    assign mix[c] = (acc[PW-1:CW+FW] != '0) ? '1 : acc[CW+FW-1:FW];
  end

  assign out_valid = v2;
  assign out_r     = res[0];
  assign out_g     = res[1];
  assign out_b     = res[2];
endmodule

module degamma_lut_chk #(
  parameter int CW   = 16,
  parameter int EW   = 17,
  parameter int NPTS = 35,
  parameter int IW   = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic          reg_addr,
  input logic [EW-1:0] reg_wdata,
  input logic [IW-1:0] idx,
  input logic          auto_inc,
  input logic          out_valid,
  input logic          out_ready,
  input logic [CW-1:0] out_r,
  input logic [CW-1:0] out_g,
  input logic [CW-1:0] out_b
);
  assert_idx_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    idx < IW'(NPTS));

  assert_index_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_addr && !reg_wdata[EW-1] && reg_wdata[EW-2:0] < (EW-1)'(NPTS))
    |=> (idx == $past(IW'(reg_wdata[EW-2:0])) && !auto_inc));

  assert_auto_keeps_idx_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_addr && reg_wdata[EW-1]) |=> ($stable(idx) && auto_inc));

  assert_auto_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_wr || reg_rd) && reg_addr && auto_inc)
    |=> (idx == (($past(idx) == IW'(NPTS - 1)) ? '0 : $past(idx) + 1'b1)));

  assert_no_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_wr || reg_rd) && reg_addr && !auto_inc) |=> $stable(idx));

  assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready)
    |=> (out_valid && $stable(out_r) && $stable(out_g) && $stable(out_b)));
endmodule

bind degamma_lut degamma_lut_chk #(.CW(CW), .EW(EW), .NPTS(NPTS), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .idx(idx), .auto_inc(auto_inc), .out_valid(out_valid),
  .out_ready(out_ready), .out_r(out_r), .out_g(out_g), .out_b(out_b)
);

// File: tb/sim_degamma_lut.sv
module sim_degamma_lut;
  logic clk = 0, rst_n = 0;
  logic csc_en = 0, dg_en = 0;
  logic reg_wr = 0, reg_rd = 0, reg_addr = 0;
  logic [16:0] reg_wdata = 0, reg_rdata;
  logic in_valid = 0, in_ready, out_valid, out_ready = 0;
  logic [15:0] in_r = 0, in_g = 0, in_b = 0, out_r, out_g, out_b;

  int checks = 0, fails = 0;
  bit done = 0;
  int m [35];
  logic [47:0] q [$];

  always #4 clk = ~clk;

  degamma_lut u0 (.*);

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] curve(logic [15:0] x);
    int s = x[15:11];
    longint w = x[10:0];
    longint v = (longint'(m[s]) * (2048 - w) + longint'(m[s+1]) * w + 1024) >>> 11;
    return (v > 65535) ? 16'hFFFF : v[15:0];
  endfunction

  function automatic logic [47:0] expect_px(logic [15:0] r, logic [15:0] g, logic [15:0] b, bit en);
    return en ? {curve(r), curve(g), curve(b)} : {r, g, b};
  endfunction

  task automatic reg_write(bit a, logic [16:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic reg_read(bit a, output logic [16:0] d);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0;
    d = reg_rdata;
  endtask

  task automatic load_curve();
    reg_write(0, 17'd0);
    reg_write(0, 17'h10000);
    for (int i = 0; i < 35; i++) reg_write(1, 17'(m[i]));
  endtask

  function automatic logic [15:0] pick();
    case ($urandom % 8)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'(($urandom % 32) << 11);
      3: return 16'((($urandom % 32) << 11) | 11'h7FF);
      default: return 16'($urandom);
    endcase
  endfunction

  task automatic stream(int n, int rdy_pct, bit en, string req);
    int sent = 0;
    bit held = 0;
    logic [47:0] hv = 0;
    while (sent < n || q.size() != 0) begin
      @(negedge clk);
      if (held) chk("R11 stall hold", {out_valid, out_r, out_g, out_b}, {1'b1, hv});
      in_valid  = (sent < n) && ($urandom % 4 != 0);
      in_r = pick(); in_g = pick(); in_b = pick();
      out_ready = ($urandom % 100) < rdy_pct;
      #1;
      if (in_valid && in_ready) begin
        q.push_back(expect_px(in_r, in_g, in_b, en));
        sent++;
      end
      if (out_valid && out_ready) begin
        if (q.size() == 0) chk(req, {out_r, out_g, out_b}, 48'h0);
        else chk(req, {out_r, out_g, out_b}, q.pop_front());
      end
      held = out_valid && !out_ready;
      hv = {out_r, out_g, out_b};
    end
    @(negedge clk);
    in_valid = 0; out_ready = 0;
  endtask

  task automatic one_px(logic [15:0] r, logic [15:0] g, logic [15:0] b, bit en, string req);
    logic [47:0] e = expect_px(r, g, b, en);
    @(negedge clk);
    in_valid = 1; in_r = r; in_g = g; in_b = b; out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    chk("R11 not early", out_valid, 0);
    @(negedge clk);
    chk("R11 two-edge latency", out_valid, 1);
    chk(req, {out_r, out_g, out_b}, e);
    @(negedge clk);
    out_ready = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [16:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;

    chk("R1 out_valid", out_valid, 0);
    chk("R11 in_ready idle", in_ready, 1);
    reg_read(0, d);
    chk("R1 index and auto", d, 0);
    reg_write(0, 17'h10000);
    for (int i = 0; i < 35; i++) begin
      reg_read(1, d);
      chk("R1/R5 identity point", d, (i <= 32) ? i * 2048 : 65536);
    end
    reg_read(0, d);
    chk("R5 read wraps index", d, 17'h10000);

    for (int i = 0; i < 35; i++) m[i] = (i <= 32) ? i * 2048 : 65536;
    csc_en = 1;
    one_px(16'h1234, 16'h0000, 16'hFFFF, 1, "R6 identity curve");

    reg_write(0, 17'd3);
    reg_read(0, d);
    chk("R2 index load", d, 3);
    reg_write(0, 17'h10014);
    reg_read(0, d);
    chk("R3 auto keeps index", d, 17'h10003);
    reg_write(0, 17'd40);
    reg_read(0, d);
    chk("R2 out of range loads 0", d, 0);
    reg_write(0, 17'd34);
    reg_write(0, 17'h10000);
    reg_write(1, 17'd777);
    reg_read(0, d);
    chk("R4 wrap after 34", d, 17'h10000);
    reg_write(0, 17'd34);
    reg_read(1, d);
    chk("R4 stored at 34", d, 777);
    reg_read(1, d);
    chk("R5 no advance when auto off", d, 777);
    reg_write(0, 17'd5);
    reg_write(1, 17'd999);
    reg_write(1, 17'd888);
    reg_read(1, d);
    chk("R4 no advance when auto off", d, 888);

    for (int i = 0; i < 35; i++) m[i] = $urandom % 65537;
    m[31] = 65536; m[32] = 65536;
    load_curve();
    reg_read(0, d);
    chk("R4 index back at 0 after full load", d, 17'h10000);
    one_px(16'hFFFF, 16'hF800, 16'h0400, 1, "R7 saturation");
    one_px(16'h2ABC, 16'h2ABC, 16'h2ABC, 1, "R8 same curve");
    stream(400, 70, 1, "R6/R8 random curve stream");

    csc_en = 0; dg_en = 1;
    one_px(16'h4321, 16'hFFFF, 16'h0001, 0, "R9 dg_en ignored when tied");
    stream(300, 50, 0, "R10 bypass stream");
    csc_en = 1;
    stream(300, 90, 1, "R9 csc_en turns stage on");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule